// File: doc/BRIEF.md
# Cache Array Maintenance Port

This block gives software direct access to the tag and data storage of a four-way set-associative cache with 16-byte lines. It sits on a simple register-style bus. Each access presents a 32-bit address and, for writes, a 32-bit data word. The top address byte selects the array. The lower address bits name the set, the way, the longword within the line, and the compare mode.

The tag array is written in two ways. A direct write replaces the tag, the per-set LRU field, and the dirty (U) and valid (V) bits of one named way. A compare write searches all four ways of a set for a valid line whose tag equals the supplied tag. If it finds one, it rewrites only the U and V bits of that way; this is used to clean or invalidate one line.

The data array is read and written one longword at a time. If a tag write would overwrite or invalidate a line that holds modified data, the block first hands the whole line to an external memory port through a valid/ready request. It keeps the bus busy until that request is accepted.

Top module: `cache_maint_port`

## Requirements
- R1: After reset every line is invalid and clean, every tag and LRU field reads zero, and `busy`, `wb_valid` and `rvalid` are low.
- R2: Top address byte 0xF0 selects the tag array and 0xF1 selects the data array. The set index is addr[9:4], the way is addr[11:10] (binary 0..3), the longword is addr[3:2] (binary 0..3), and the compare-mode bit is addr[3] for tag writes.
- R3: A read accepted while `busy` is low raises `rvalid` for exactly the next cycle. For the tag array, `rdata` is {tag[31:10], LRU[9:4], 2'b00, U[1], V[0]}.
- R4: Data-array reads and writes move one 32-bit longword, and never change the tag array or start a write-back.
- R5: A direct tag write (addr[3]=0) sets the way's tag from wdata[31:10], its U from wdata[1] and its V from wdata[0], and sets the set's LRU field from wdata[9:4].
- R6: Whenever V is written as 0, U of that way becomes 0, whatever wdata[1] holds.
- R7: A direct tag write to a way with U=1 and V=1 first writes back the old line, and updates the entry only after the write-back is accepted.
- R8: A compare write (addr[3]=1) hits a way only if the way is valid and its tag equals wdata[31:10]. It updates only U and V of the hit way, leaving the tag and LRU unchanged. If several ways hit, the lowest-numbered way wins.
- R9: A compare write that hits no way changes nothing and starts no write-back.
- R10: A compare write whose hit way has U=1 writes that line back before updating U and V.
- R11: A write-back presents `wb_addr` = {old tag, index} and `wb_data` = {longword 3, 2, 1, 0}. These are held stable with `wb_valid` until `wb_ready`, and `busy` stays high during that time. Bus requests made while `busy` is high are ignored.
- R12: Reads of any other top address byte return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus request, accepted on a rising edge when `busy` is low |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Access address |
| wdata | input | 32 | Write data |
| busy | output | 1 | High while a write-back is outstanding |
| rvalid | output | 1 | Read data valid, one cycle after the read is accepted |
| rdata | output | 32 | Read data |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_addr | output | 28 | Line address of the write-back (tag and index) |
| wb_data | output | 128 | Four longwords of the line, longword 0 in the low bits |

## Verification
On every cycle, the assertions check four things: the one-cycle read latency, that `rvalid` never appears without a read, that a pending write-back holds its address and data until accepted, and that data-array writes never start a write-back. They also check that every tag word read back obeys the rule that an invalid line is never dirty. The bench scenarios cover everything else. These include the hit rules of compare writes (valid required, lowest way wins), that misses leave the entry untouched, and the exact line contents and address handed out on a write-back. They also show that the entry changes only after the handshake, and that accesses made while busy are dropped.

// File: rtl/cache_maint_port.sv
module cache_maint_port #(
  parameter int IDX_W = 6,
  parameter int LRU_W = 6,
  parameter logic [7:0] TAG_SPACE = 8'hF0,
  parameter logic [7:0] DATA_SPACE = 8'hF1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               we,
  input  logic [31:0]        addr,
  input  logic [31:0]        wdata,
  output logic               busy,
  output logic               rvalid,
  output logic [31:0]        rdata,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [27:0]        wb_addr,
  output logic [127:0]       wb_data
);
  localparam int WAYS  = 4;
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = 28 - IDX_W;
  localparam int PAD_W = IDX_W - LRU_W + 2;

  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [LRU_W-1:0] lru_q [SETS];
  logic [WAYS-1:0]  v_q   [SETS];
  logic [WAYS-1:0]  u_q   [SETS];
  logic [31:0]      dat_q [WAYS][SETS][4];

  assign busy = wb_valid;

  wire accept = req && !busy;
  wire in_tag = addr[31:24] == TAG_SPACE;
  wire in_dat = addr[31:24] == DATA_SPACE;
  wire [IDX_W-1:0] a_idx = addr[4 +: IDX_W];
  wire [1:0] a_way   = addr[4+IDX_W +: 2];
  wire [1:0] a_lw    = addr[3:2];
  wire       a_assoc = addr[3];
  wire [TAG_W-1:0] d_tag = wdata[31 -: TAG_W];
  wire [LRU_W-1:0] d_lru = wdata[4 +: LRU_W];
  wire d_u = wdata[1];
  wire d_v = wdata[0];

  logic unused_bits;
  assign unused_bits = ^{addr[23:6+IDX_W], addr[1:0], wdata[3:2]};

  logic [WAYS-1:0] hit;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit[w] = v_q[a_idx][w] && (tag_q[w][a_idx] == d_tag);
  end

  logic [1:0] hit_way;
  always_comb begin
    hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (hit[w]) hit_way = 2'(w);
  end

  wire [1:0] sel_way   = a_assoc ? hit_way : a_way;
  wire       tgt_dirty = u_q[a_idx][sel_way] && v_q[a_idx][sel_way];
  wire       do_op     = accept && we && in_tag && (!a_assoc || |hit);
  wire       need_wb   = do_op && tgt_dirty;

  logic [127:0] line_rd;
  always_comb
    for (int k = 0; k < 4; k++) line_rd[32*k +: 32] = dat_q[sel_way][a_idx][k];

  logic [IDX_W-1:0] p_idx;
  logic [1:0]       p_way;
  logic             p_assoc, p_u, p_v;
  logic [TAG_W-1:0] p_tag;
  logic [LRU_W-1:0] p_lru;

  wire from_wb = wb_valid && wb_ready;
  wire c_en    = from_wb || (do_op && !tgt_dirty);
  wire [IDX_W-1:0] c_idx   = from_wb ? p_idx   : a_idx;
  wire [1:0]       c_way   = from_wb ? p_way   : sel_way;
  wire             c_assoc = from_wb ? p_assoc : a_assoc;
  wire [TAG_W-1:0] c_tag   = from_wb ? p_tag   : d_tag;
  wire [LRU_W-1:0] c_lru   = from_wb ? p_lru   : d_lru;
  wire             c_u     = from_wb ? p_u     : d_u;
  wire             c_v     = from_wb ? p_v     : d_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s]   <= '0;
        u_q[s]   <= '0;
        lru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[w][s] <= '0;
      end
    end else if (c_en) begin
      v_q[c_idx][c_way] <= c_v;
      u_q[c_idx][c_way] <= c_u && c_v;
      if (!c_assoc) begin
        tag_q[c_way][c_idx] <= c_tag;
        lru_q[c_idx]        <= c_lru;
      end
    end
  end

  always_ff @(posedge clk)
    if (accept && we && in_dat) dat_q[a_way][a_idx][a_lw] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
      p_idx    <= '0;
      p_way    <= '0;
      p_assoc  <= 1'b0;
      p_tag    <= '0;
      p_lru    <= '0;
      p_u      <= 1'b0;
      p_v      <= 1'b0;
    end else if (need_wb) begin
      wb_valid <= 1'b1;
      wb_addr  <= {tag_q[sel_way][a_idx], a_idx};
      wb_data  <= line_rd;
      p_idx    <= a_idx;
      p_way    <= sel_way;
      p_assoc  <= a_assoc;
      p_tag    <= d_tag;
      p_lru    <= d_lru;
      p_u      <= d_u;
      p_v      <= d_v;
    end else if (from_wb) begin
      wb_valid <= 1'b0;
    end
  end

  logic rd_tag_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid   <= 1'b0;
      rdata    <= '0;
      rd_tag_q <= 1'b0;
    end else begin
      rvalid   <= accept && !we;
      rd_tag_q <= accept && !we && in_tag;
      if (accept && !we) begin
        if (in_tag)
          rdata <= {tag_q[a_way][a_idx], lru_q[a_idx], {PAD_W{1'b0}},
                    u_q[a_idx][a_way], v_q[a_idx][a_way]};
        else if (in_dat)
          rdata <= dat_q[a_way][a_idx][a_lw];
        else
          rdata <= '0;
      end
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data)); // R11
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req && !busy && !we |=> rvalid); // R3
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !busy && !we) |=> !rvalid); // R3
  AST_INVALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && rd_tag_q |-> !(rdata[1] && !rdata[0])); // R6
  AST_DATA_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    req && !busy && we && addr[31:24] != TAG_SPACE |=> !wb_valid); // R4
endmodule

// File: tb/cache_maint_port_test.sv
module cache_maint_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, req = 0, we = 0, wb_ready = 0;
  logic [31:0] addr = 0, wdata = 0;
  logic busy, rvalid, wb_valid;
  logic [31:0] rdata;
  logic [27:0] wb_addr;
  logic [127:0] wb_data;

  int checks = 0, errors = 0, wb_count = 0, wb_wait = 0;
  logic [31:0] rd_exp_q[$];
  string rd_tag_q[$];
  logic [27:0] wb_addr_q[$];
  logic [127:0] wb_data_q[$];
  string wb_tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_maint_port uut (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .busy(busy), .rvalid(rvalid), .rdata(rdata), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data));

  function automatic logic [31:0] ta(input logic [1:0] way, input logic [5:0] idx, input logic assoc);
    return {8'hF0, 12'h0, way, idx, assoc, 3'b000};
  endfunction
  function automatic logic [31:0] da(input logic [1:0] way, input logic [5:0] idx, input logic [1:0] lw);
    return {8'hF1, 12'h0, way, idx, lw, 2'b00};
  endfunction
  function automatic logic [31:0] tw(input logic [21:0] tag, input logic [5:0] lru, input logic u, input logic v);
    return {tag, lru, 2'b00, u, v};
  endfunction

  task automatic check(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string r);
    @(negedge clk); req = 1; we = 0; addr = a;
    rd_exp_q.push_back(exp); rd_tag_q.push_back(r);
    @(negedge clk); req = 0;
  endtask

  task automatic expect_wb(input logic [27:0] a, input logic [127:0] d, input string r);
    wb_addr_q.push_back(a); wb_data_q.push_back(d); wb_tag_q.push_back(r);
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (rd_exp_q.size() == 0) check(0, "R3 unexpected rvalid", rdata, 0);
      else begin
        logic [31:0] e;
        string r;
        e = rd_exp_q.pop_front(); r = rd_tag_q.pop_front();
        check(rdata === e, r, rdata, e);
      end
    end
  end

  always @(negedge clk) begin
    wb_ready = 1'b0;
    if (rst_n && wb_valid) begin
      if (wb_wait == 0) begin
        wb_count++;
        check(busy === 1'b1, "R11 busy during write-back", busy, 1);
        if (wb_addr_q.size() == 0) check(0, "R9 unexpected write-back", wb_addr, 0);
        else begin
          logic [27:0] ea;
          logic [127:0] ed;
          string r;
          ea = wb_addr_q.pop_front(); ed = wb_data_q.pop_front(); r = wb_tag_q.pop_front();
          check(wb_addr === ea, {r, " wb_addr"}, wb_addr, ea);
          check(wb_data === ed, {r, " wb_data"}, wb_data, ed);
        end
      end
      wb_wait++;
      if (wb_wait == 3) begin wb_ready = 1'b1; wb_wait = 0; end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && wb_valid === 0 && rvalid === 0, "R1 idle outputs", {busy, wb_valid, rvalid}, 0);
    bus_read(ta(2, 5, 0), 0, "R1 tag entry after reset");

    // R4 data array longwords, R2 field decode
    for (int k = 0; k < 4; k++) bus_write(da(1, 3, 2'(k)), 32'hA000_0000 + k);
    bus_write(da(2, 3, 2), 32'h2222_2222);
    bus_read(da(1, 3, 2), 32'hA000_0002, "R4 data longword 2 way 1");
    bus_read(da(2, 3, 2), 32'h2222_2222, "R2 way field selects way 2");

    // R5 direct tag write into an invalid way: no write-back
    bus_write(ta(1, 3, 0), tw(22'h12345, 6'h2A, 1, 1));
    bus_read(ta(1, 3, 0), tw(22'h12345, 6'h2A, 1, 1), "R5 direct tag write");
    bus_write(da(1, 3, 3), 32'h0000_00B3);
    bus_read(ta(1, 3, 0), tw(22'h12345, 6'h2A, 1, 1), "R4 data write leaves tag");

    // R6 V=0 forces U=0
    bus_write(ta(2, 3, 0), tw(22'h00777, 6'h05, 1, 0));
    bus_read(ta(2, 3, 0), tw(22'h00777, 6'h05, 0, 0), "R6 U cleared with V");

    // R7 / R11 overwrite of dirty line, poke while busy ignored
    bus_write(da(0, 0, 0), 32'h5555_0000);
    expect_wb({22'h12345, 6'd3}, {32'hB3, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000}, "R7");
    @(negedge clk); req = 1; we = 1; addr = ta(1, 3, 0); wdata = tw(22'h3ABCD, 6'h11, 0, 1);
    @(negedge clk); addr = da(0, 0, 0); wdata = 32'hDEAD_BEEF;
    @(negedge clk); req = 0;
    while (busy) @(negedge clk);
    bus_read(da(0, 0, 0), 32'h5555_0000, "R11 request while busy ignored");
    bus_read(ta(1, 3, 0), tw(22'h3ABCD, 6'h11, 0, 1), "R7 entry updated after write-back");

    // R9 compare miss
    bus_write(ta(3, 3, 0), tw(22'h00042, 6'h11, 1, 1));
    snap = wb_count;
    bus_write(ta(0, 3, 1), tw(22'h0FFFF, 6'h00, 0, 0));
    bus_read(ta(3, 3, 0), tw(22'h00042, 6'h11, 1, 1), "R9 miss leaves entry");
    check(wb_count == snap, "R9 miss starts no write-back", wb_count, snap);

    // R8 invalid way with equal tag does not hit
    bus_write(ta(0, 3, 1), tw(22'h00777, 6'h00, 1, 1));
    bus_read(ta(2, 3, 0), tw(22'h00777, 6'h11, 0, 0), "R8 invalid way never hits");

    // R10 compare hit on dirty way
    for (int k = 0; k < 4; k++) bus_write(da(3, 3, 2'(k)), 32'hC000_0000 + k);
    expect_wb({22'h00042, 6'd3}, {32'hC000_0003, 32'hC000_0002, 32'hC000_0001, 32'hC000_0000}, "R10");
    bus_write(ta(0, 3, 1), tw(22'h00042, 6'h3F, 0, 0));
    bus_read(ta(3, 3, 0), tw(22'h00042, 6'h11, 0, 0), "R10 U/V cleared, tag and LRU kept");

    // R8 clean hit sets U, then R6 invalidate of now dirty line
    snap = wb_count;
    bus_write(ta(0, 3, 1), tw(22'h3ABCD, 6'h00, 1, 1));
    bus_read(ta(1, 3, 0), tw(22'h3ABCD, 6'h11, 1, 1), "R8 clean hit updates U and V only");
    check(wb_count == snap, "R8 clean hit starts no write-back", wb_count, snap);
    expect_wb({22'h3ABCD, 6'd3}, {32'hB3, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000}, "R10");
    bus_write(ta(0, 3, 1), tw(22'h3ABCD, 6'h00, 1, 0));
    bus_read(ta(1, 3, 0), tw(22'h3ABCD, 6'h11, 0, 0), "R6 invalidate clears U");

    // R8 lowest way wins
    bus_write(ta(0, 7, 0), tw(22'h0ABCD, 6'h01, 0, 1));
    bus_write(ta(2, 7, 0), tw(22'h0ABCD, 6'h01, 0, 1));
    bus_write(ta(0, 7, 1), tw(22'h0ABCD, 6'h00, 1, 1));
    bus_read(ta(0, 7, 0), tw(22'h0ABCD, 6'h01, 1, 1), "R8 way 0 wins");
    bus_read(ta(2, 7, 0), tw(22'h0ABCD, 6'h01, 0, 1), "R8 way 2 untouched");

    // R12 other spaces
    bus_read(32'h1234_5670, 0, "R12 unmapped read is zero");
    bus_write({8'hF2, da(0, 0, 0)[23:0]}, 32'h0BAD_0BAD);
    bus_read(da(0, 0, 0), 32'h5555_0000, "R12 unmapped write ignored");

    repeat (5) @(negedge clk);
    check(rd_exp_q.size() == 0 && wb_addr_q.size() == 0, "R3 all expected results seen",
          rd_exp_q.size() + wb_addr_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule